// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the general registers of a processor core that runs in several privilege modes. Software addresses registers by an architectural index from 0 to 15, and the block steers each access to the physical copy that belongs to the mode currently in force. Registers 0 to 7 are common to every mode. Registers 8 to 12 have a second copy that only the fast-interrupt mode sees. Registers 13 and 14 have one copy per mode group. Index 15 is the program counter, which is kept outside the block and only passed through on reads.

The block keeps its own 5-bit mode register. A one-cycle mode-change request switches the visible bank. In the same edge it stores the caller's current status word into the saved-status slot of the mode being entered, and it loads that mode's link register (index 14) with a supplied return address. A separate port reads and writes the saved-status slot of the current mode. Reads are combinational. Writes take effect at the next rising clock edge.

Top module: `bankreg_file`

## Requirements
- R1: A synchronous reset clears every physical register and every saved-status slot to zero. It sets the mode to Supervisor (5'b10011) and drives `illegal_mode` low.
- R2: Indices 0 to 7 address one shared copy in every mode. A write appears on either read port from the next cycle, and the two read ports select independently.
- R3: Indices 8 to 12 have two copies. The copy used in fast-interrupt mode (5'b10001) is separate from the copy used in every other mode.
- R4: Indices 13 and 14 have six copies. User (5'b10000) and System (5'b11111) share one copy, and fast-interrupt (10001), interrupt (10010), Supervisor (10011), Abort (10111) and Undefined (11011) each have their own.
- R5: When `chg_req` is high at a clock edge, the mode becomes `chg_mode` and index 14 of the new mode receives `chg_ret`. If the same edge also writes the same physical register through the write port, the return address wins.
- R6: A mode change into fast-interrupt, interrupt, Supervisor, Abort or Undefined copies `stat_in` into that mode's saved-status slot. A change into User, System or an unlisted encoding saves nothing.
- R7: `ss_rdata` shows the current mode's saved-status slot, or `stat_in` when the mode has no slot. `ss_we` writes the current mode's slot and is ignored in a mode without one. If a capture in the same edge targets the same slot, the capture wins.
- R8: A register write in the same cycle as a mode change lands in the bank of the mode in force before the change.
- R9: Reading index 15 returns `pc_in`, and writing index 15 changes no register.
- R10: A mode value outside the seven listed encodings raises `illegal_mode`. For banking it is treated as User, with no saved-status slot and no fast-interrupt copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ra_idx | input | 4 | Read port A architectural index |
| ra_data | output | DATA_W | Read port A data |
| rb_idx | input | 4 | Read port B architectural index |
| rb_data | output | DATA_W | Read port B data |
| we | input | 1 | Register write enable |
| w_idx | input | 4 | Write architectural index |
| w_data | input | DATA_W | Write data |
| pc_in | input | DATA_W | Program counter value returned for index 15 |
| chg_req | input | 1 | Mode-change request |
| chg_mode | input | 5 | Mode to enter |
| chg_ret | input | DATA_W | Return address loaded into the new mode's index 14 |
| stat_in | input | DATA_W | Current status word from the core |
| ss_we | input | 1 | Saved-status write enable |
| ss_wdata | input | DATA_W | Saved-status write data |
| ss_rdata | output | DATA_W | Saved-status read data |
| mode_out | output | 5 | Current mode |
| illegal_mode | output | 1 | Current mode is not a listed encoding |

## Verification
The assertions assume that reset is held for at least one clock edge before the first access, and that every input is a known value at each rising edge. They also assume that a mode change and a write to the same physical register are decided only by the stated priority. The stimulus asserts reset first and changes inputs only on falling edges. It draws modes from the seven listed encodings plus one unlisted value, so the fallback to User banking is exercised without leaving any input undefined.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

    localparam int IDX_W  = 4;
    localparam int MODE_W = 5;
    localparam int NLOW   = 8;
    localparam int NHI    = 5;
    localparam int NBANK  = 6;
    localparam int NSLOT  = NBANK - 1;
    localparam int NPHYS  = NLOW + 2 * NHI + 2 * NBANK;
    localparam int PW     = $clog2(NPHYS);
    localparam int SW     = $clog2(NSLOT);
    localparam int HI_ALT = NLOW + NHI;
    localparam int SP_BASE = NLOW + 2 * NHI;
    localparam int LR_BASE = SP_BASE + NBANK;
    localparam logic [IDX_W-1:0] PC_IDX = 4'd15;

    typedef enum logic [MODE_W-1:0] {
        MD_USR = 5'b10000,
        MD_FIQ = 5'b10001,
        MD_IRQ = 5'b10010,
        MD_SVC = 5'b10011,
        MD_ABT = 5'b10111,
        MD_UND = 5'b11011,
        MD_SYS = 5'b11111
    } mode_e;

    typedef struct packed {
        logic          en;
        logic [PW-1:0] ix;
    } phys_wr_t;

    function automatic logic mode_legal(input logic [MODE_W-1:0] m);
        case (m)
            MD_USR, MD_FIQ, MD_IRQ, MD_SVC, MD_ABT, MD_UND, MD_SYS: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [2:0] bank_of(input logic [MODE_W-1:0] m);
        case (m)
            MD_FIQ:  return 3'd1;
            MD_IRQ:  return 3'd2;
            MD_SVC:  return 3'd3;
            MD_ABT:  return 3'd4;
            MD_UND:  return 3'd5;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic has_slot(input logic [MODE_W-1:0] m);
        return bank_of(m) != 3'd0;
    endfunction

    function automatic logic [SW-1:0] slot_of(input logic [MODE_W-1:0] m);
        return SW'(bank_of(m) - 3'd1);
    endfunction

    function automatic logic [PW-1:0] phys_of(input logic [IDX_W-1:0] idx,
                                              input logic [MODE_W-1:0] m);
        if (idx < IDX_W'(NLOW))
            return PW'(idx);
        else if (idx < IDX_W'(NLOW + NHI))
            return (m == MD_FIQ) ? PW'(HI_ALT + int'(idx) - NLOW) : PW'(idx);
        else if (idx == 4'd13)
            return PW'(SP_BASE + int'(bank_of(m)));
        else if (idx == 4'd14)
            return PW'(LR_BASE + int'(bank_of(m)));
        else
            return '0;
    endfunction

endpackage

// File: rtl/bankreg_map.sv
module bankreg_map
    import bankreg_pkg::*;
(
    input  logic [IDX_W-1:0]  arch_idx,
    input  logic [MODE_W-1:0] mode,
    output logic [PW-1:0]     phys_ix,
    output logic              is_pc
);
    always_comb begin
        phys_ix = phys_of(arch_idx, mode);
        is_pc   = (arch_idx == PC_IDX);
    end
endmodule

// File: rtl/bankreg_store.sv
module bankreg_store
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NRD    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  phys_wr_t          wr,
    input  logic [DATA_W-1:0] wr_val,
    input  phys_wr_t          lk,
    input  logic [DATA_W-1:0] lk_val,
    input  logic [PW-1:0]     rd_ix  [NRD],
    output logic [DATA_W-1:0] rd_val [NRD]
);
    logic [DATA_W-1:0] mem_q [NPHYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPHYS; i++) mem_q[i] <= '0;
        end else begin
            if (wr.en) mem_q[wr.ix] <= wr_val;
            if (lk.en) mem_q[lk.ix] <= lk_val;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_val[g] = mem_q[rd_ix[g]];
    end

    assert_link_load_R5: assert property (@(posedge clk) disable iff (rst)
        lk.en |=> mem_q[$past(lk.ix)] == $past(lk_val));

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (wr.en && !(lk.en && lk.ix == wr.ix)) |=> mem_q[$past(wr.ix)] == $past(wr_val));
endmodule

// File: rtl/bankreg_saved.sv
module bankreg_saved
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SW-1:0]     wr_slot,
    input  logic [DATA_W-1:0] wr_val,
    input  logic              cap_en,
    input  logic [SW-1:0]     cap_slot,
    input  logic [DATA_W-1:0] cap_val,
    input  logic [SW-1:0]     rd_slot,
    output logic [DATA_W-1:0] rd_val
);
    logic [DATA_W-1:0] slot_q [NSLOT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSLOT; i++) slot_q[i] <= '0;
        end else begin
            if (wr_en)  slot_q[wr_slot]  <= wr_val;
            if (cap_en) slot_q[cap_slot] <= cap_val;
        end
    end

    assign rd_val = slot_q[rd_slot];

    assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
        cap_en |=> slot_q[$past(cap_slot)] == $past(cap_val));
endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        ra_idx,
    output logic [DATA_W-1:0] ra_data,
    input  logic [3:0]        rb_idx,
    output logic [DATA_W-1:0] rb_data,
    input  logic              we,
    input  logic [3:0]        w_idx,
    input  logic [DATA_W-1:0] w_data,
    input  logic [DATA_W-1:0] pc_in,
    input  logic              chg_req,
    input  logic [4:0]        chg_mode,
    input  logic [DATA_W-1:0] chg_ret,
    input  logic [DATA_W-1:0] stat_in,
    input  logic              ss_we,
    input  logic [DATA_W-1:0] ss_wdata,
    output logic [DATA_W-1:0] ss_rdata,
    output logic [4:0]        mode_out,
    output logic              illegal_mode
);
    localparam int NRD = 2;

    logic [MODE_W-1:0] mode_q;
    logic [IDX_W-1:0]  rd_arch [NRD];
    logic [PW-1:0]     rd_phys [NRD];
    logic              rd_pc   [NRD];
    logic [DATA_W-1:0] rd_raw  [NRD];
    logic [DATA_W-1:0] rd_out  [NRD];
    logic [PW-1:0]     w_phys;
    logic              w_pc;
    logic [PW-1:0]     lk_phys;
    logic              lk_pc;
    phys_wr_t          wr_req, lk_req;
    logic [DATA_W-1:0] ss_slot_val;

    always_ff @(posedge clk) begin
        if (rst)          mode_q <= MD_SVC;
        else if (chg_req) mode_q <= chg_mode;
    end

    assign rd_arch[0] = ra_idx;
    assign rd_arch[1] = rb_idx;

    for (genvar g = 0; g < NRD; g++) begin : g_rport
        bankreg_map u_map (
            .arch_idx (rd_arch[g]),
            .mode     (mode_q),
            .phys_ix  (rd_phys[g]),
            .is_pc    (rd_pc[g])
        );
        assign rd_out[g] = rd_pc[g] ? pc_in : rd_raw[g];
    end

    bankreg_map u_wmap (
        .arch_idx (w_idx),
        .mode     (mode_q),
        .phys_ix  (w_phys),
        .is_pc    (w_pc)
    );

    bankreg_map u_lmap (
        .arch_idx (4'd14),
        .mode     (chg_mode),
        .phys_ix  (lk_phys),
        .is_pc    (lk_pc)
    );

    always_comb begin
        wr_req.en = we && !w_pc;
        wr_req.ix = w_phys;
        lk_req.en = chg_req && !lk_pc;
        lk_req.ix = lk_phys;
    end

    bankreg_store #(.DATA_W(DATA_W), .NRD(NRD)) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr_req),
        .wr_val (w_data),
        .lk     (lk_req),
        .lk_val (chg_ret),
        .rd_ix  (rd_phys),
        .rd_val (rd_raw)
    );

    bankreg_saved #(.DATA_W(DATA_W)) u_saved (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (ss_we && has_slot(mode_q)),
        .wr_slot  (slot_of(mode_q)),
        .wr_val   (ss_wdata),
        .cap_en   (chg_req && has_slot(chg_mode)),
        .cap_slot (slot_of(chg_mode)),
        .cap_val  (stat_in),
        .rd_slot  (slot_of(mode_q)),
        .rd_val   (ss_slot_val)
    );

    assign ra_data      = rd_out[0];
    assign rb_data      = rd_out[1];
    assign ss_rdata     = has_slot(mode_q) ? ss_slot_val : stat_in;
    assign mode_out     = mode_q;
    assign illegal_mode = !mode_legal(mode_q);

    assert_mode_follows_R5: assert property (@(posedge clk) disable iff (rst)
        chg_req |=> mode_out == $past(chg_mode));

    assert_mode_holds_R5: assert property (@(posedge clk) disable iff (rst)
        !chg_req |=> $stable(mode_out));

    assert_pc_passthru_R9: assert property (@(posedge clk) disable iff (rst)
        (ra_idx == PC_IDX) |-> ra_data == pc_in);
endmodule

// File: tb/sim_bankreg_file.sv
`timescale 1ns/1ps
module sim_bankreg_file;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  ra_idx, rb_idx, w_idx;
    logic [31:0] ra_data, rb_data, w_data, pc_in, chg_ret, stat_in, ss_wdata, ss_rdata;
    logic        we, chg_req, ss_we, illegal_mode;
    logic [4:0]  chg_mode, mode_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    string focus = "";

    // behavioural reference state
    logic [31:0] m_low [8];
    logic [31:0] m_hi_std [5];
    logic [31:0] m_hi_fast [5];
    logic [31:0] m_sp [6];
    logic [31:0] m_lr [6];
    logic [31:0] m_sav [6];
    logic [4:0]  m_mode;

    always #2.5 clk = ~clk;

    bankreg_file u0 (
        .clk(clk), .rst(rst),
        .ra_idx(ra_idx), .ra_data(ra_data), .rb_idx(rb_idx), .rb_data(rb_data),
        .we(we), .w_idx(w_idx), .w_data(w_data), .pc_in(pc_in),
        .chg_req(chg_req), .chg_mode(chg_mode), .chg_ret(chg_ret), .stat_in(stat_in),
        .ss_we(ss_we), .ss_wdata(ss_wdata), .ss_rdata(ss_rdata),
        .mode_out(mode_out), .illegal_mode(illegal_mode)
    );

    function automatic int grp(input logic [4:0] m);
        if (m == 5'b10001) return 1;
        if (m == 5'b10010) return 2;
        if (m == 5'b10011) return 3;
        if (m == 5'b10111) return 4;
        if (m == 5'b11011) return 5;
        return 0;
    endfunction

    function automatic bit known_mode(input logic [4:0] m);
        return grp(m) != 0 || m == 5'b10000 || m == 5'b11111;
    endfunction

    function automatic logic [31:0] mread(input logic [3:0] i);
        if (i == 4'd15) return pc_in;
        if (i < 4'd8) return m_low[i];
        if (i < 4'd13) return (grp(m_mode) == 1) ? m_hi_fast[i-8] : m_hi_std[i-8];
        if (i == 4'd13) return m_sp[grp(m_mode)];
        return m_lr[grp(m_mode)];
    endfunction

    function automatic string rtag(input logic [3:0] i);
        if (!known_mode(m_mode)) return "R10";
        if (i == 4'd15) return "R9";
        if (i < 4'd8) return "R2";
        if (i < 4'd13) return "R3";
        return "R4";
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", req, focus, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_low[i] = '0;
        for (int i = 0; i < 5; i++) begin m_hi_std[i] = '0; m_hi_fast[i] = '0; end
        for (int i = 0; i < 6; i++) begin m_sp[i] = '0; m_lr[i] = '0; m_sav[i] = '0; end
        m_mode = 5'b10011;
    endtask

    task automatic idle();
        we = 0; w_idx = 0; w_data = 0; chg_req = 0; chg_mode = 5'b10000; chg_ret = 0;
        ss_we = 0; ss_wdata = 0;
    endtask

    // inputs already driven (falling edge); compare, then take the edge and advance the model
    task automatic step();
        int g;
        #1;
        chk(rtag(ra_idx), ra_data, mread(ra_idx));
        chk(rtag(rb_idx), rb_data, mread(rb_idx));
        chk("R5", {27'd0, mode_out}, {27'd0, m_mode});
        chk("R10", {31'd0, illegal_mode}, {31'd0, !known_mode(m_mode)});
        chk("R7", ss_rdata, (grp(m_mode) != 0) ? m_sav[grp(m_mode)] : stat_in);
        @(posedge clk);
        g = grp(m_mode);
        if (we && w_idx != 4'd15) begin
            if (w_idx < 4'd8) m_low[w_idx] = w_data;
            else if (w_idx < 4'd13) begin
                if (g == 1) m_hi_fast[w_idx-8] = w_data; else m_hi_std[w_idx-8] = w_data;
            end else if (w_idx == 4'd13) m_sp[g] = w_data;
            else m_lr[g] = w_data;
        end
        if (ss_we && g != 0) m_sav[g] = ss_wdata;
        if (chg_req) begin
            if (grp(chg_mode) != 0) m_sav[grp(chg_mode)] = stat_in;
            m_lr[grp(chg_mode)] = chg_ret;
            m_mode = chg_mode;
        end
        @(negedge clk);
        idle();
        stat_in = $urandom; pc_in = $urandom;
    endtask

    task automatic go_mode(input logic [4:0] m, input logic [31:0] ret);
        chg_req = 1; chg_mode = m; chg_ret = ret;
        step();
    endtask

    task automatic put(input logic [3:0] i, input logic [31:0] v);
        we = 1; w_idx = i; w_data = v;
        step();
    endtask

    task automatic look(input logic [3:0] a, input logic [3:0] b);
        ra_idx = a; rb_idx = b;
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [4:0] picks [8];
        logic [31:0] keep;
        picks = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011, 5'b11111, 5'b00101};
        idle(); ra_idx = 0; rb_idx = 13; stat_in = 32'h600d_0001; pc_in = 32'h0000_0100;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();

        // R1: reset state
        focus = "R1";
        #1;
        chk("R1", {27'd0, mode_out}, 32'h13);
        chk("R1", {31'd0, illegal_mode}, 32'd0);
        chk("R1", ra_data, 32'd0);
        chk("R1", rb_data, 32'd0);
        chk("R1", ss_rdata, 32'd0);

        // R2/R3/R4: fill every index in Supervisor
        focus = "fill";
        for (int i = 0; i < 15; i++) put(4'(i), 32'hA000_0000 + 32'(i));
        for (int i = 0; i < 16; i++) look(4'(i), 4'(15 - i));

        // R3/R5: enter fast-interrupt, its high copies differ, r14 holds return
        focus = "R3";
        stat_in = 32'h5151_0001;
        go_mode(5'b10001, 32'h0000_0F1C);
        for (int i = 8; i < 15; i++) look(4'(i), 4'(i - 8));
        for (int i = 8; i < 13; i++) put(4'(i), 32'hF000_0000 + 32'(i));
        go_mode(5'b10000, 32'h0000_1111);
        for (int i = 8; i < 15; i++) look(4'(i), 4'(i));

        // R6: capture into interrupt mode's saved slot
        focus = "R6";
        stat_in = 32'hCAFE_0006; keep = stat_in;
        go_mode(5'b10010, 32'h0000_2222);
        #1; chk("R6", ss_rdata, keep);
        look(4'd14, 4'd13);

        // R7: saved-status write in a mode with a slot, then System has none
        focus = "R7";
        ss_we = 1; ss_wdata = 32'h7777_0007; step();
        look(0, 0);
        go_mode(5'b11111, 32'h0000_3333);
        ss_we = 1; ss_wdata = 32'hDEAD_0007; step();
        look(4'd13, 4'd14);
        go_mode(5'b10010, 32'h0000_4444);
        look(4'd14, 4'd13);
        ss_we = 1; ss_wdata = 32'h1234_0007; chg_req = 1; chg_mode = 5'b10010;
        chg_ret = 32'h55; stat_in = 32'hBEEF_0007; step();
        look(0, 14);

        // R8: write with mode change lands in old bank
        focus = "R8";
        we = 1; w_idx = 13; w_data = 32'h8888_0013; chg_req = 1; chg_mode = 5'b10111;
        chg_ret = 32'h0000_0ABC; step();
        look(4'd13, 4'd14);
        go_mode(5'b10010, 32'h0000_0DEF);
        look(4'd13, 4'd14);

        // R5: link load beats same-cycle write to the shared bank
        focus = "R5";
        go_mode(5'b10000, 32'h0000_1000);
        we = 1; w_idx = 14; w_data = 32'h0BAD_0014; chg_req = 1; chg_mode = 5'b11111;
        chg_ret = 32'h600D_0014; step();
        look(4'd14, 4'd13);

        // R9: index 15 write has no effect
        focus = "R9";
        put(4'd15, 32'hFFFF_FFFF);
        for (int i = 0; i < 16; i++) look(4'(i), 4'd15);

        // R10: unlisted mode behaves as User, no slot
        focus = "R10";
        stat_in = 32'h1010_0010;
        go_mode(5'b00101, 32'h0000_0A0A);
        look(4'd13, 4'd14);
        put(4'd13, 32'h1010_0013);
        go_mode(5'b10000, 32'h0000_0B0B);
        look(4'd13, 4'd8);

        // random mix, compared every cycle
        focus = "rand";
        for (int n = 0; n < 3000; n++) begin
            ra_idx = 4'($urandom); rb_idx = 4'($urandom);
            we = ($urandom % 2) == 0; w_idx = 4'($urandom); w_data = $urandom;
            chg_req = ($urandom % 8) == 0; chg_mode = picks[$urandom % 8]; chg_ret = $urandom;
            ss_we = ($urandom % 6) == 0; ss_wdata = $urandom;
            step();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule